// File: doc/BRIEF.md
# Memory BIST Pattern Engine

This block is a built-in self-test engine for a memory region. Software loads a small table of 64-bit pattern words and a start offset and entry count through a word-addressed register port. It then launches a write pass, which stores table entry k at offset+k, followed by a read pass. The read pass fetches the same addresses and compares each returned beat with the table entry it should hold. A single run covers the region once. A continuous run keeps wrapping over the region until software halts it.

The memory side is a plain synchronous request port. A request is a single-cycle `mem_req` carrying address, write enable and write data. A read answers with a single-cycle `mem_rvalid` and `mem_rdata` after any latency the memory needs. At most one read is in flight at a time. Results are kept in read-only registers: a saturating mismatch counter, the address of the most recent mismatch, and the 64-bit word that mismatched. Software reads the counter after the read pass to judge pass or fail.

Top module: `mbist_engine`

## Requirements
- R1: After reset the engine is idle and issues no request. Register words 0, 1, 4, 5, 6 and 7 all read zero.
- R2: Word 0 is the mode register. Bit 0 enables a write pass, bit 1 selects a read-compare pass (bit 1 wins when both are set), and bit 2 selects continuous duration. A launch is ignored when bits 0 and 1 are both clear, or when the length register (word 3) is zero.
- R3: Writing 1 to bit 0 of word 1 launches a run. Bit 0 of word 1 reads 1 while the run is busy and clears by itself when a single-duration run ends. A launch written while busy is ignored.
- R4: A write pass issues writes of table entry (k mod DEPTH) to address offset+k for k = 0 .. length-1, in order. The offset comes from word 2. Each write is followed by exactly 2 request-free cycles before the next.
- R5: A read pass issues reads of offset+k in the same order. It waits for `mem_rvalid` and issues the next read in the cycle directly after the return, with no extra idle cycle.
- R6: Each returned beat that differs from its expected entry increments the mismatch counter (word 4, ERR_W bits, saturating at all ones). It also loads word 5 with that beat's address, word 6 with bits 63:32 of the returned data and word 7 with bits 31:0.
- R7: A launch clears words 4, 5, 6 and 7 to zero.
- R8: A continuous run wraps from the last entry back to entry 0 until halted. Writing 1 to bit 8 of word 1 halts it. If a read is outstanding, the engine waits for the return and compares it, then goes idle with no further request.
- R9: Writing the value 0 to word 0 while busy halts the run in the same way as bit 8 of word 1.
- R10: Table entry k is loaded through word 2*DEPTH+2k (bits 31:0) and word 2*DEPTH+2k+1 (bits 63:32).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | RA_W (6) | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr`, combinational |
| mem_req | output | 1 | Memory request, one cycle per access |
| mem_we | output | 1 | 1 for a write request, 0 for a read |
| mem_addr | output | ADDR_W | Request address |
| mem_wdata | output | 64 | Write data |
| mem_rvalid | input | 1 | Read data return strobe |
| mem_rdata | input | 64 | Returned read data |

## Verification
The hardest case to reach is a halt that lands while a read is still outstanding. The engine must compare that last beat and then go quiet. To get there, the bench gives its memory model a long read latency and corrupts the first word of the region. It writes the halt in the cycle right after the first read request, then checks three things: the engine stays busy until the return, the mismatch is counted, and no request follows. Counter saturation is reached by running the bench with a narrow counter over a region whose every word is corrupted, in continuous mode, and halting through the mode register.

// File: rtl/mbist_pkg.sv
package mbist_pkg;
  localparam int WORD_W = 64;
  localparam int HALF_W = 32;

  // register word indices
  localparam int REG_MODE  = 0;
  localparam int REG_RUN   = 1;
  localparam int REG_OFFS  = 2;
  localparam int REG_LEN   = 3;
  localparam int REG_ERRS  = 4;
  localparam int REG_FADDR = 5;
  localparam int REG_FHI   = 6;
  localparam int REG_FLO   = 7;

  localparam int RUN_GO_BIT   = 0;
  localparam int RUN_HALT_BIT = 8;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_ISSUE,
    SQ_GAP,
    SQ_WAIT
  } sq_state_e;
endpackage

// File: rtl/mbist_patstore.sv
module mbist_patstore #(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [IDX_W-1:0]            wr_idx,
  input  logic                        wr_hi,
  input  logic [mbist_pkg::HALF_W-1:0] wr_data,
  input  logic [IDX_W-1:0]            rd_idx,
  output logic [mbist_pkg::WORD_W-1:0] rd_word
);
  import mbist_pkg::*;

  logic [DEPTH-1:0][WORD_W-1:0] ent_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_q <= '0;
    end else if (wr_en) begin
      for (int k = 0; k < DEPTH; k++) begin
        if (wr_idx == IDX_W'(k)) begin
          if (wr_hi) ent_q[k][WORD_W-1:HALF_W] <= wr_data;
          else       ent_q[k][HALF_W-1:0]      <= wr_data;
        end
      end
    end
  end

  assign rd_word = ent_q[rd_idx];
endmodule

// File: rtl/mbist_seq.sv
module mbist_seq #(
  parameter int ADDR_W  = 16,
  parameter int IDX_W   = 4,
  parameter int GAP_CYC = 2,
  localparam int LEN_W  = IDX_W + 1,
  localparam int GAP_W  = (GAP_CYC > 1) ? $clog2(GAP_CYC) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_req,
  input  logic              kill_req,
  input  logic              mode_wr,
  input  logic              mode_rd,
  input  logic              mode_cont,
  input  logic [ADDR_W-1:0] offset,
  input  logic [LEN_W-1:0]  length,
  input  logic              mem_rvalid,
  output logic              busy,
  output logic              launch,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [IDX_W-1:0]  pat_idx,
  output logic              cmp_valid
);
  import mbist_pkg::*;

  sq_state_e         state_q, state_d;
  logic [LEN_W-1:0]  beat_q, beat_d;
  logic [GAP_W-1:0]  gap_q, gap_d;
  logic              halt_q, halt_d;
  logic              run_rd_q, run_cont_q;
  logic [LEN_W-1:0]  run_len_q;
  logic [ADDR_W-1:0] run_off_q;
  logic              last_beat;
  logic [LEN_W-1:0]  beat_wrap;

  assign launch    = (state_q == SQ_IDLE) && go_req && !kill_req &&
                     (mode_wr || mode_rd) && (length != '0);
  assign last_beat = (beat_q == run_len_q - LEN_W'(1));
  assign beat_wrap = last_beat ? '0 : beat_q + LEN_W'(1);

  always_comb begin
    state_d = state_q;
    beat_d  = beat_q;
    gap_d   = gap_q;
    halt_d  = halt_q;
    case (state_q)
      SQ_IDLE: begin
        halt_d = 1'b0;
        if (launch) begin
          state_d = SQ_ISSUE;
          beat_d  = '0;
        end
      end
      SQ_ISSUE: begin
        if (run_rd_q) begin
          state_d = SQ_WAIT;
          if (kill_req) halt_d = 1'b1;
        end else if (kill_req || (last_beat && !run_cont_q)) begin
          state_d = SQ_IDLE;
        end else begin
          beat_d  = beat_wrap;
          gap_d   = '0;
          state_d = SQ_GAP;
        end
      end
      SQ_GAP: begin
        if (kill_req)                          state_d = SQ_IDLE;
        else if (gap_q == GAP_W'(GAP_CYC - 1)) state_d = SQ_ISSUE;
        else                                   gap_d   = gap_q + GAP_W'(1);
      end
      SQ_WAIT: begin
        if (kill_req) halt_d = 1'b1;
        if (mem_rvalid) begin
          if (halt_q || kill_req || (last_beat && !run_cont_q)) begin
            state_d = SQ_IDLE;
          end else begin
            beat_d  = beat_wrap;
            state_d = SQ_ISSUE;
          end
        end
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      beat_q  <= '0;
      gap_q   <= '0;
      halt_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      beat_q  <= beat_d;
      gap_q   <= gap_d;
      halt_q  <= halt_d;
    end
  end

  // run settings are captured once per launch
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_rd_q   <= 1'b0;
      run_cont_q <= 1'b0;
      run_len_q  <= '0;
      run_off_q  <= '0;
    end else if (launch) begin
      run_rd_q   <= mode_rd;
      run_cont_q <= mode_cont;
      run_len_q  <= length;
      run_off_q  <= offset;
    end
  end

  assign busy      = (state_q != SQ_IDLE);
  assign mem_req   = (state_q == SQ_ISSUE);
  assign mem_we    = (state_q == SQ_ISSUE) && !run_rd_q;
  assign mem_addr  = run_off_q + ADDR_W'(beat_q);
  assign pat_idx   = beat_q[IDX_W-1:0];
  assign cmp_valid = (state_q == SQ_WAIT) && mem_rvalid;
endmodule

// File: rtl/mbist_capture.sv
module mbist_capture #(
  parameter int ADDR_W = 16,
  parameter int ERR_W  = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clear,
  input  logic                         cmp_valid,
  input  logic [mbist_pkg::WORD_W-1:0] exp_word,
  input  logic [mbist_pkg::WORD_W-1:0] got_word,
  input  logic [ADDR_W-1:0]            beat_addr,
  output logic [ERR_W-1:0]             err_cnt,
  output logic [ADDR_W-1:0]            fail_addr,
  output logic [mbist_pkg::WORD_W-1:0] fail_word
);
  import mbist_pkg::*;

  logic             miss;
  logic             upd_en;
  logic [ERR_W-1:0] err_d;

  assign miss   = cmp_valid && (exp_word != got_word);
  assign upd_en = clear || miss;

  always_comb begin
    if (clear)             err_d = '0;
    else if (&err_cnt)     err_d = err_cnt;
    else                   err_d = err_cnt + ERR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_cnt   <= '0;
      fail_addr <= '0;
      fail_word <= '0;
    end else if (upd_en) begin
      err_cnt   <= err_d;
      fail_addr <= clear ? '0 : beat_addr;
      fail_word <= clear ? '0 : got_word;
    end
  end
endmodule

// File: rtl/mbist_engine.sv
module mbist_engine #(
  parameter int ADDR_W = 16,
  parameter int DEPTH  = 16,
  parameter int ERR_W  = 32,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int LEN_W = IDX_W + 1,
  localparam int RA_W  = IDX_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wen,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [63:0]       mem_wdata,
  input  logic              mem_rvalid,
  input  logic [63:0]       mem_rdata
);
  import mbist_pkg::*;

  logic rst_meta, rst_n_int;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta  <= 1'b0;
      rst_n_int <= 1'b0;
    end else begin
      rst_meta  <= 1'b1;
      rst_n_int <= rst_meta;
    end
  end

  logic              wr_mode, wr_run, wr_offs, wr_len, wr_pat;
  logic [2:0]        mode_q;
  logic [ADDR_W-1:0] offs_q;
  logic [LEN_W-1:0]  len_q;
  logic              go_req, kill_req;
  logic              busy, launch, cmp_valid;
  logic [IDX_W-1:0]  pat_idx;
  logic [WORD_W-1:0] exp_word;
  logic [ERR_W-1:0]  err_cnt;
  logic [ADDR_W-1:0] fail_addr;
  logic [WORD_W-1:0] fail_word;

  assign wr_mode = reg_wen && (reg_addr == RA_W'(REG_MODE));
  assign wr_run  = reg_wen && (reg_addr == RA_W'(REG_RUN));
  assign wr_offs = reg_wen && (reg_addr == RA_W'(REG_OFFS));
  assign wr_len  = reg_wen && (reg_addr == RA_W'(REG_LEN));
  assign wr_pat  = reg_wen && reg_addr[RA_W-1];

  assign go_req   = wr_run && reg_wdata[RUN_GO_BIT];
  assign kill_req = (wr_run && reg_wdata[RUN_HALT_BIT]) ||
                    (wr_mode && (reg_wdata == 32'd0));

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) mode_q <= '0;
    else if (wr_mode) mode_q <= reg_wdata[2:0];
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) offs_q <= '0;
    else if (wr_offs) offs_q <= reg_wdata[ADDR_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) len_q <= '0;
    else if (wr_len) len_q <= reg_wdata[LEN_W-1:0];
  end

  mbist_patstore #(.DEPTH(DEPTH)) u_pat (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .wr_en   (wr_pat),
    .wr_idx  (reg_addr[IDX_W:1]),
    .wr_hi   (reg_addr[0]),
    .wr_data (reg_wdata),
    .rd_idx  (pat_idx),
    .rd_word (exp_word)
  );

  mbist_seq #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .GAP_CYC(2)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .go_req     (go_req),
    .kill_req   (kill_req),
    .mode_wr    (mode_q[0]),
    .mode_rd    (mode_q[1]),
    .mode_cont  (mode_q[2]),
    .offset     (offs_q),
    .length     (len_q),
    .mem_rvalid (mem_rvalid),
    .busy       (busy),
    .launch     (launch),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .pat_idx    (pat_idx),
    .cmp_valid  (cmp_valid)
  );

  assign mem_wdata = exp_word;

  mbist_capture #(.ADDR_W(ADDR_W), .ERR_W(ERR_W)) u_cap (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .clear     (launch),
    .cmp_valid (cmp_valid),
    .exp_word  (exp_word),
    .got_word  (mem_rdata),
    .beat_addr (mem_addr),
    .err_cnt   (err_cnt),
    .fail_addr (fail_addr),
    .fail_word (fail_word)
  );

  always_comb begin
    reg_rdata = 32'd0;
    case (reg_addr)
      RA_W'(REG_MODE):  reg_rdata = {29'd0, mode_q};
      RA_W'(REG_RUN):   reg_rdata = {31'd0, busy};
      RA_W'(REG_OFFS):  reg_rdata = 32'(offs_q);
      RA_W'(REG_LEN):   reg_rdata = 32'(len_q);
      RA_W'(REG_ERRS):  reg_rdata = 32'(err_cnt);
      RA_W'(REG_FADDR): reg_rdata = 32'(fail_addr);
      RA_W'(REG_FHI):   reg_rdata = fail_word[WORD_W-1:HALF_W];
      RA_W'(REG_FLO):   reg_rdata = fail_word[HALF_W-1:0];
      default:          reg_rdata = 32'd0;
    endcase
  end
endmodule

// File: rtl/mbist_engine_chk.sv
module mbist_engine_chk #(
  parameter int ERR_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mem_req,
  input logic             mem_we,
  input logic             busy,
  input logic             launch,
  input logic [ERR_W-1:0] err_cnt
);
  assert_req_only_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy);

  assert_write_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |=> !mem_req);

  assert_one_read_inflight_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |=> !mem_req);

  assert_err_no_decrease_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !launch |=> (err_cnt >= $past(err_cnt)));

  assert_clear_on_launch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> (err_cnt == '0));
endmodule

bind mbist_engine mbist_engine_chk #(.ERR_W(ERR_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n_int),
  .mem_req (mem_req),
  .mem_we  (mem_we),
  .busy    (busy),
  .launch  (launch),
  .err_cnt (err_cnt)
);

// File: tb/mbist_engine_test.sv
module mbist_engine_test;
  localparam int ADDR_W = 16;
  localparam int DEPTH  = 16;
  localparam int ERR_W  = 3;
  localparam int RA_W   = 6;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              rst_n = 1'b0;
  logic              reg_wen = 1'b0;
  logic [RA_W-1:0]   reg_addr = '0;
  logic [31:0]       reg_wdata = '0;
  logic [31:0]       reg_rdata;
  logic              mem_req, mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [63:0]       mem_wdata;
  logic              mem_rvalid = 1'b0;
  logic [63:0]       mem_rdata = '0;

  mbist_engine #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .ERR_W(ERR_W)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  int checks = 0, errors = 0, cyc = 0, n_pop = 0;
  int prev_wr = -1, last_rv = -1, rd_lat = 1, rcnt = 0;
  bit mon_on = 0;
  logic [63:0] mem [256];
  logic [63:0] pat [DEPTH];
  logic [63:0] rhold;

  typedef struct { bit we; logic [ADDR_W-1:0] addr; logic [63:0] data; } req_t;
  req_t expq[$];

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // memory model
  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (rcnt > 0) begin
      if (rcnt == 1) begin mem_rvalid <= 1'b1; mem_rdata <= rhold; end
      rcnt <= rcnt - 1;
    end
    if (mem_req && mem_we) mem[mem_addr[7:0]] <= mem_wdata;
    if (mem_req && !mem_we) begin rcnt <= rd_lat; rhold <= mem[mem_addr[7:0]]; end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (mon_on) begin
      if (mem_req) begin
        if (expq.size() == 0) begin
          check(0, "R3/R8 unexpected request", {48'd0, mem_addr}, 64'd0);
        end else begin
          req_t e;
          e = expq.pop_front();
          n_pop++;
          check(mem_we == e.we, "R4/R5 request kind", {63'd0, mem_we}, {63'd0, e.we});
          check(mem_addr == e.addr, "R4/R5/R8 request address", {48'd0, mem_addr}, {48'd0, e.addr});
          if (e.we) begin
            check(mem_wdata == e.data, "R4 write data", mem_wdata, e.data);
            if (prev_wr >= 0)
              check(cyc - prev_wr == 3, "R4 write spacing", 64'(cyc - prev_wr), 64'd3);
            prev_wr = cyc;
          end else if (last_rv >= 0) begin
            check(cyc == last_rv + 1, "R5 read follows return", 64'(cyc), 64'(last_rv + 1));
          end
        end
      end
      if (mem_rvalid) last_rv = cyc;
    end
  end

  task automatic reg_write(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_wen = 1'b1; reg_addr = a[RA_W-1:0]; reg_wdata = d;
    @(negedge clk);
    reg_wen = 1'b0;
  endtask

  task automatic reg_read(input int a, output logic [31:0] d);
    reg_addr = a[RA_W-1:0];
    #1;
    d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      reg_read(1, v);
      if (v[0] == 1'b0) break;
    end
  endtask

  task automatic push_pass(input bit we, input int off, input int len, input int passes);
    for (int p = 0; p < passes; p++)
      for (int k = 0; k < len; k++) begin
        req_t e;
        e.we = we; e.addr = ADDR_W'(off + k); e.data = pat[k % DEPTH];
        expq.push_back(e);
      end
  endtask

  int          exp_cnt;
  logic [15:0] exp_addr;
  logic [63:0] exp_word;
  task automatic predict(input int off, input int len);
    exp_cnt = 0; exp_addr = '0; exp_word = '0;
    for (int k = 0; k < len; k++)
      if (mem[off + k] != pat[k % DEPTH]) begin
        if (exp_cnt < 7) exp_cnt++;
        exp_addr = 16'(off + k);
        exp_word = mem[off + k];
      end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    for (int i = 0; i < 256; i++) mem[i] = 64'd0;
    for (int k = 0; k < DEPTH; k++)
      pat[k] = {32'hC0DE_0000 + 32'(k * 17), 32'h5A5A_0F00 ^ 32'(k << 4)};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    mon_on = 1;

    // R1 reset state
    foreach (v[i]) ;
    for (int a = 0; a < 8; a++) begin
      if (a == 2 || a == 3) continue;
      reg_read(a, v);
      check(v == 32'd0, $sformatf("R1 reset word %0d", a), 64'(v), 64'd0);
    end
    check(mem_req == 1'b0, "R1 no request after reset", {63'd0, mem_req}, 64'd0);

    // R10 load table
    for (int k = 0; k < DEPTH; k++) begin
      reg_write(2 * DEPTH + 2 * k, pat[k][31:0]);
      reg_write(2 * DEPTH + 2 * k + 1, pat[k][63:32]);
    end

    // R2 launch ignored with mode bits clear or zero length
    reg_write(2, 32'h20);
    reg_write(3, 32'd5);
    reg_write(1, 32'h1);
    reg_read(1, v);
    check(v[0] == 1'b0, "R2 launch ignored, mode bits clear", 64'(v[0]), 64'd0);
    reg_write(0, 32'h1);
    reg_write(3, 32'd0);
    reg_write(1, 32'h1);
    reg_read(1, v);
    check(v[0] == 1'b0, "R2 launch ignored, zero length", 64'(v[0]), 64'd0);
    repeat (5) @(negedge clk);

    // R4/R10 single write pass, second launch while busy ignored (R3)
    reg_write(3, 32'd5);
    push_pass(1, 32'h20, 5, 1);
    prev_wr = -1;
    reg_write(1, 32'h1);
    reg_read(1, v);
    check(v[0] == 1'b1, "R3 busy while running", 64'(v[0]), 64'd1);
    repeat (3) @(negedge clk);
    reg_write(1, 32'h1);
    wait_idle();
    check(expq.size() == 0, "R3/R4 all writes issued, run self-cleared", 64'(expq.size()), 64'd0);
    for (int k = 0; k < 5; k++)
      check(mem[32 + k] == pat[k], "R10 stored entry", mem[32 + k], pat[k]);

    // R5 clean read pass, both mode bits set -> read
    reg_write(0, 32'h3);
    rd_lat = 1;
    push_pass(0, 32'h20, 5, 1);
    last_rv = -1;
    reg_write(1, 32'h1);
    wait_idle();
    reg_read(4, v);
    check(v == 32'd0, "R5/R2 clean read pass error count", 64'(v), 64'd0);
    check(expq.size() == 0, "R5 all reads issued", 64'(expq.size()), 64'd0);

    // R6 corrupted read pass
    mem[34] = mem[34] ^ 64'h1;
    mem[36] = mem[36] ^ 64'hFF00_0000_0000_0000;
    predict(32, 5);
    rd_lat = 3;
    push_pass(0, 32'h20, 5, 1);
    last_rv = -1;
    reg_write(1, 32'h1);
    wait_idle();
    reg_read(4, v);
    check(v == 32'(exp_cnt), "R6 mismatch count", 64'(v), 64'(exp_cnt));
    reg_read(5, v);
    check(v == 32'(exp_addr), "R6 last failing address", 64'(v), 64'(exp_addr));
    reg_read(6, v);
    check(v == exp_word[63:32], "R6 failing word high", 64'(v), 64'(exp_word[63:32]));
    reg_read(7, v);
    check(v == exp_word[31:0], "R6 failing word low", 64'(v), 64'(exp_word[31:0]));

    // R7 launch clears results
    push_pass(0, 32'h20, 5, 1);
    last_rv = -1;
    reg_write(1, 32'h1);
    reg_read(4, v);
    check(v == 32'd0, "R7 count cleared on launch", 64'(v), 64'd0);
    reg_read(5, v);
    check(v == 32'd0, "R7 address cleared on launch", 64'(v), 64'd0);
    wait_idle();
    mem[34] = pat[2];
    mem[36] = pat[4];

    // R8 continuous write halted with bit 8
    reg_write(0, 32'h5);
    reg_write(2, 32'h40);
    reg_write(3, 32'd3);
    push_pass(1, 32'h40, 3, 3);
    n_pop = 0;
    prev_wr = -1;
    reg_write(1, 32'h1);
    wait (n_pop == 7);
    reg_write(1, 32'h100);
    expq.delete();
    repeat (10) @(negedge clk);
    check(n_pop == 7, "R8 no request after halt", 64'(n_pop), 64'd7);
    reg_read(1, v);
    check(v[0] == 1'b0, "R8 idle after halt", 64'(v[0]), 64'd0);
    for (int k = 0; k < 3; k++)
      check(mem[64 + k] == pat[k], "R8 wrapped writes", mem[64 + k], pat[k]);

    // R9 + R6 saturation: continuous read of a fully corrupted region, halted by zero mode write
    for (int k = 0; k < 3; k++) mem[48 + k] = ~pat[k];
    reg_write(0, 32'h6);
    reg_write(2, 32'h30);
    rd_lat = 1;
    push_pass(0, 32'h30, 3, 12);
    last_rv = -1;
    reg_write(1, 32'h1);
    repeat (60) @(negedge clk);
    reg_write(0, 32'h0);
    expq.delete();
    wait_idle();
    repeat (5) @(negedge clk);
    reg_read(1, v);
    check(v[0] == 1'b0, "R9 zero mode write halts run", 64'(v[0]), 64'd0);
    reg_read(4, v);
    check(v == 32'd7, "R6 count saturates at all ones", 64'(v), 64'd7);

    // R8 halt while a read is outstanding
    for (int k = 0; k < 3; k++) mem[32 + k] = pat[k];
    mem[32] = mem[32] ^ 64'h8000;
    reg_write(0, 32'h6);
    reg_write(2, 32'h20);
    rd_lat = 6;
    push_pass(0, 32'h20, 3, 2);
    last_rv = -1;
    n_pop = 0;
    reg_write(1, 32'h1);
    reg_write(1, 32'h100);
    expq.delete();
    reg_read(1, v);
    check(v[0] == 1'b1, "R8 busy until outstanding read returns", 64'(v[0]), 64'd1);
    for (int i = 0; i < 20; i++) begin
      if (mem_rvalid) break;
      @(negedge clk);
    end
    @(negedge clk);
    reg_read(1, v);
    check(v[0] == 1'b0, "R8 idle after final return", 64'(v[0]), 64'd0);
    reg_read(4, v);
    check(v == 32'd1, "R8 final beat compared", 64'(v), 64'd1);
    repeat (10) @(negedge clk);
    check(n_pop == 1, "R8 single read before halt", 64'(n_pop), 64'd1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule